// File: doc/BRIEF.md
# Involuntary Priority Counter Arbiter

This block arbitrates among eight hardware counter cells, each of which can ask for its counter in memory to be stepped up or down by one. Requests arrive as single-cycle pulses and collect in a pending bank. A transfer strobe copies the whole bank into a synchronised snapshot. A fixed-priority encoder works on that snapshot alone, so the selection cannot change partway through a memory cycle.

For the selected cell the block tells the sequencer which subsequence to run: increment, decrement or no-op. When the read-select strobe is high, it places the counter's memory address (a fixed base plus the cell index) on the read bus. After the shared adder has done its work, the sum arrives on the write bus with its overflow bits. A write-overflow strobe then retires the serviced request. It can also pass a carry on to another counter or raise a one-cycle interrupt request. A separate strobe sends adder overflows into cell 0, the overflow counter.

All strobes and request pulses are plain control pins sampled on the rising clock edge. The read bus is combinational from the read-select strobe and the snapshot. No interface at the edge of the block has back-pressure, so there is no valid/ready pair.

Top module: `prio_ctr_arbiter`

## Requirements
- R1: An active-low `rst_n`, or `gen_clear` high at a clock edge, empties the pending bank, the snapshot and both interrupt outputs. Afterwards `sel_idx` reads 7 and `subseq` reads no-op. `gen_clear` takes precedence over every other input in the same cycle.
- R2: A high bit in `ext_up` or `ext_dn` at a clock edge sets the matching pending up or down request of that cell.
- R3: `xfer_stb` copies all pending bits into the snapshot in one edge. Pending bits that change without a transfer leave `sel_idx` and `subseq` unchanged.
- R4: `sel_idx` is the lowest index whose snapshot up or down bit is set. Index 0 has the highest priority. When no cell is active, `sel_idx` is 7.
- R5: `subseq` encodes 0 = no-op, 1 = increment, 2 = decrement. For the selected cell, up alone gives increment and down alone gives decrement. Both bits set, or neither, gives no-op.
- R6: While `rsel_stb` is high, `rd_bus` equals 28 (octal 034) plus `sel_idx`. Otherwise `rd_bus` is zero.
- R7: `wovr_stb` clears the pending up bit of the selected cell if its snapshot up bit is set. It clears the pending down bit if the snapshot down bit is set.
- R8: `wovr_stb` with a positive overflow while cell 2 is selected sets the pending up bit of cell 1.
- R9: `wovr_stb` with a positive overflow sets `t3_irq` for exactly the following cycle when cell 3 is selected, and sets `dl_irq` for that cycle when cell 4 is selected. A negative overflow or any other cell raises neither.
- R10: `wovc_stb` sets the pending up bit of cell 0 on a positive overflow and the pending down bit of cell 0 on a negative overflow.
- R11: If a set (external pulse or carry) and a clear hit the same pending bit in one cycle, the bit ends up set.
- R12: Overflow is decoded from `wr_bus[15:14]`: 01 means positive and 10 means negative. 00 and 11 mean no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_clear | input | 1 | Synchronous general clear |
| ext_up | input | 8 | Up-request pulses, one per cell |
| ext_dn | input | 8 | Down-request pulses, one per cell |
| xfer_stb | input | 1 | Copy pending bits into the snapshot |
| rsel_stb | input | 1 | Drive the selected counter address on `rd_bus` |
| wovr_stb | input | 1 | Retire the selected request and route its overflow |
| wovc_stb | input | 1 | Route the write-bus overflow into cell 0 |
| wr_bus | input | 16 | Adder result carrying the overflow bits |
| rd_bus | output | 16 | Counter address or zero |
| sel_idx | output | 3 | Selected cell index |
| subseq | output | 2 | Subsequence code for the sequencer |
| t3_irq | output | 1 | Third-timer interrupt pulse |
| dl_irq | output | 1 | Fourth-timer (downlink) interrupt pulse |

## Verification
The assertions take for granted that every control input is a clean, defined level at each clock edge after reset. They also assume the overflow bits on `wr_bus` are meaningful whenever a write-overflow or overflow-counter strobe is high. The stimulus drives every input half a cycle away from the active edge. It always sets `wr_bus` to a fully defined value, and spreads the strobes and request pulses at random, so that back-to-back strobes, conflicting up/down pairs and clears that meet new requests all occur.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    SUB_NOP = 2'd0,
    SUB_INC = 2'd1,
    SUB_DEC = 2'd2
  } subseq_e;

  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_POS  = 2'd1,
    OVF_NEG  = 2'd2
  } ovf_e;

  function automatic ovf_e ovf_decode(input logic [1:0] top);
    case (top)
      2'b01:   return OVF_POS;
      2'b10:   return OVF_NEG;
      default: return OVF_NONE;
    endcase
  endfunction

  function automatic subseq_e subseq_of(input logic up, input logic dn);
    if (up && !dn)      return SUB_INC;
    else if (dn && !up) return SUB_DEC;
    else                return SUB_NOP;
  endfunction
endpackage

// File: rtl/ipc_req_bank.sv
module ipc_req_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gen_clear,
  input  logic [N-1:0] set_up,
  input  logic [N-1:0] set_dn,
  input  logic [N-1:0] clr_up,
  input  logic [N-1:0] clr_dn,
  output logic [N-1:0] pend_up,
  output logic [N-1:0] pend_dn
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_up[g] <= 1'b0;
        pend_dn[g] <= 1'b0;
      end else if (gen_clear) begin
        pend_up[g] <= 1'b0;
        pend_dn[g] <= 1'b0;
      end else begin
        pend_up[g] <= set_up[g] | (pend_up[g] & ~clr_up[g]);
        pend_dn[g] <= set_dn[g] | (pend_dn[g] & ~clr_dn[g]);
      end
    end
  end
endmodule

// File: rtl/ipc_sync_sel.sv
module ipc_sync_sel
  import ipc_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_clear,
  input  logic          xfer,
  input  logic [N-1:0]  pend_up,
  input  logic [N-1:0]  pend_dn,
  output logic [IW-1:0] sel,
  output logic          sel_up,
  output logic          sel_dn,
  output subseq_e       sub
);
  logic [N-1:0] sync_up, sync_dn, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_up <= '0;
      sync_dn <= '0;
    end else if (gen_clear) begin
      sync_up <= '0;
      sync_dn <= '0;
    end else if (xfer) begin
      sync_up <= pend_up;
      sync_dn <= pend_dn;
    end
  end

  assign active = sync_up | sync_dn;

  always_comb begin
    sel = IW'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) sel = IW'(i);
    end
  end

  assign sel_up = sync_up[sel];
  assign sel_dn = sync_dn[sel];
  assign sub    = subseq_of(sel_up, sel_dn);
endmodule

// File: rtl/ipc_ovf_route.sv
module ipc_ovf_route
  import ipc_pkg::*;
#(
  parameter int N        = 8,
  parameter int IW       = $clog2(N),
  parameter int OVC_IDX  = 0,
  parameter int TMR2_IDX = 1,
  parameter int TMR1_IDX = 2,
  parameter int TMR3_IDX = 3,
  parameter int TMR4_IDX = 4
) (
  input  logic          wovr,
  input  logic          wovc,
  input  ovf_e          ovf,
  input  logic [IW-1:0] sel,
  input  logic          sel_up,
  input  logic          sel_dn,
  output logic [N-1:0]  clr_up,
  output logic [N-1:0]  clr_dn,
  output logic [N-1:0]  carry_up,
  output logic [N-1:0]  carry_dn,
  output logic          t3_hit,
  output logic          dl_hit
);
  logic pos_r;

  assign pos_r  = wovr && (ovf == OVF_POS);
  assign t3_hit = pos_r && (sel == IW'(TMR3_IDX));
  assign dl_hit = pos_r && (sel == IW'(TMR4_IDX));

  always_comb begin
    clr_up   = '0;
    clr_dn   = '0;
    carry_up = '0;
    carry_dn = '0;
    if (wovr) begin
      clr_up[sel] = sel_up;
      clr_dn[sel] = sel_dn;
    end
    if (pos_r && (sel == IW'(TMR1_IDX))) carry_up[TMR2_IDX] = 1'b1;
    if (wovc && (ovf == OVF_POS)) carry_up[OVC_IDX] = 1'b1;
    if (wovc && (ovf == OVF_NEG)) carry_dn[OVC_IDX] = 1'b1;
  end
endmodule

// File: rtl/prio_ctr_arbiter.sv
module prio_ctr_arbiter
  import ipc_pkg::*;
#(
  parameter int          N         = 8,
  parameter int          DW        = 16,
  parameter logic [15:0] ADDR_BASE = 16'o034
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gen_clear,
  input  logic [N-1:0]         ext_up,
  input  logic [N-1:0]         ext_dn,
  input  logic                 xfer_stb,
  input  logic                 rsel_stb,
  input  logic                 wovr_stb,
  input  logic                 wovc_stb,
  input  logic [DW-1:0]        wr_bus,
  output logic [DW-1:0]        rd_bus,
  output logic [$clog2(N)-1:0] sel_idx,
  output logic [1:0]           subseq,
  output logic                 t3_irq,
  output logic                 dl_irq
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  pend_up, pend_dn, clr_up, clr_dn, carry_up, carry_dn;
  logic [IW-1:0] sel;
  logic          sel_up, sel_dn, t3_hit, dl_hit;
  subseq_e       sub;
  ovf_e          ovf;

  assign ovf = ovf_decode(wr_bus[DW-1:DW-2]);

  ipc_req_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_n), .gen_clear(gen_clear),
    .set_up(ext_up | carry_up), .set_dn(ext_dn | carry_dn),
    .clr_up(clr_up), .clr_dn(clr_dn),
    .pend_up(pend_up), .pend_dn(pend_dn)
  );

  ipc_sync_sel #(.N(N), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n), .gen_clear(gen_clear), .xfer(xfer_stb),
    .pend_up(pend_up), .pend_dn(pend_dn),
    .sel(sel), .sel_up(sel_up), .sel_dn(sel_dn), .sub(sub)
  );

  ipc_ovf_route #(.N(N), .IW(IW)) u_route (
    .wovr(wovr_stb), .wovc(wovc_stb), .ovf(ovf),
    .sel(sel), .sel_up(sel_up), .sel_dn(sel_dn),
    .clr_up(clr_up), .clr_dn(clr_dn),
    .carry_up(carry_up), .carry_dn(carry_dn),
    .t3_hit(t3_hit), .dl_hit(dl_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t3_irq <= 1'b0;
      dl_irq <= 1'b0;
    end else if (gen_clear) begin
      t3_irq <= 1'b0;
      dl_irq <= 1'b0;
    end else begin
      t3_irq <= t3_hit;
      dl_irq <= dl_hit;
    end
  end

  assign sel_idx = sel;
  assign subseq  = sub;
  assign rd_bus  = rsel_stb ? (DW'(ADDR_BASE) + DW'(sel)) : '0;
endmodule

// File: rtl/prio_ctr_arbiter_chk.sv
module prio_ctr_arbiter_chk #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gen_clear,
  input logic          rsel_stb,
  input logic          wovr_stb,
  input logic [DW-1:0] wr_bus,
  input logic [DW-1:0] rd_bus,
  input logic [IW-1:0] sel_idx,
  input logic [1:0]    subseq,
  input logic          t3_irq,
  input logic          dl_irq
);
  AST_RDBUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsel_stb |-> (rd_bus >= DW'(28) && rd_bus <= DW'(28 + N - 1))); // R6
  AST_T3_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    t3_irq |-> ($past(wovr_stb) && $past(sel_idx) == IW'(3)
                && $past(wr_bus[DW-1:DW-2]) == 2'b01)); // R9
  AST_DL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    dl_irq |-> ($past(wovr_stb) && $past(sel_idx) == IW'(4)
                && $past(wr_bus[DW-1:DW-2]) == 2'b01)); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gen_clear) |-> (sel_idx == IW'(N - 1) && subseq == 2'd0
                          && !t3_irq && !dl_irq)); // R1
  AST_SUBSEQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    subseq != 2'd3); // R5
endmodule

bind prio_ctr_arbiter prio_ctr_arbiter_chk #(.N(N), .DW(DW), .IW($clog2(N))) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_clear(gen_clear), .rsel_stb(rsel_stb),
  .wovr_stb(wovr_stb), .wr_bus(wr_bus), .rd_bus(rd_bus), .sel_idx(sel_idx),
  .subseq(subseq), .t3_irq(t3_irq), .dl_irq(dl_irq)
);

// File: tb/test_prio_ctr_arbiter.sv
module test_prio_ctr_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_clear = 1'b0;
  logic [7:0]  ext_up = '0, ext_dn = '0;
  logic        xfer_stb = 1'b0, rsel_stb = 1'b0, wovr_stb = 1'b0, wovc_stb = 1'b0;
  logic [15:0] wr_bus = '0;
  logic [15:0] rd_bus;
  logic [2:0]  sel_idx;
  logic [1:0]  subseq;
  logic        t3_irq, dl_irq;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_pu = '0, m_pd = '0, m_su = '0, m_sd = '0;
  logic       m_t3 = 1'b0, m_dl = 1'b0;

  always #5 clk = ~clk;

  prio_ctr_arbiter i_prio_ctr_arbiter (
    .clk(clk), .rst_n(rst_n), .gen_clear(gen_clear), .ext_up(ext_up), .ext_dn(ext_dn),
    .xfer_stb(xfer_stb), .rsel_stb(rsel_stb), .wovr_stb(wovr_stb), .wovc_stb(wovc_stb),
    .wr_bus(wr_bus), .rd_bus(rd_bus), .sel_idx(sel_idx), .subseq(subseq),
    .t3_irq(t3_irq), .dl_irq(dl_irq)
  );

  function automatic logic [2:0] f_sel(input logic [7:0] u, input logic [7:0] d);
    for (int i = 0; i < 8; i++) if (u[i] | d[i]) return 3'(i);
    return 3'd7;
  endfunction

  function automatic logic [1:0] f_sub(input logic u, input logic d);
    if (u && !d) return 2'd1;
    if (d && !u) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [2:0] s;
    s = f_sel(m_su, m_sd);
    chk({tag, " R4 sel"}, 16'(sel_idx), 16'(s));
    chk({tag, " R5 subseq"}, 16'(subseq), 16'(f_sub(m_su[s], m_sd[s])));
    chk({tag, " R6 rd_bus"}, rd_bus, rsel_stb ? 16'(28 + s) : 16'd0);
    chk({tag, " R9 t3"}, 16'(t3_irq), 16'(m_t3));
    chk({tag, " R9 dl"}, 16'(dl_irq), 16'(m_dl));
  endtask

  // one clock: model update from inputs held across the edge, check at negedge
  task automatic step(input string tag);
    logic [2:0] s;
    logic pos, neg;
    logic [7:0] cu, cd, su, sd;
    @(posedge clk);
    s   = f_sel(m_su, m_sd);
    pos = (wr_bus[15:14] == 2'b01);  // R12
    neg = (wr_bus[15:14] == 2'b10);
    cu = '0; cd = '0; su = ext_up; sd = ext_dn;
    if (wovr_stb) begin cu[s] = m_su[s]; cd[s] = m_sd[s]; end  // R7
    if (wovr_stb && pos && s == 3'd2) su[1] = 1'b1;             // R8
    if (wovc_stb && pos) su[0] = 1'b1;                          // R10
    if (wovc_stb && neg) sd[0] = 1'b1;
    if (gen_clear) begin
      m_pu = '0; m_pd = '0; m_su = '0; m_sd = '0; m_t3 = 0; m_dl = 0;
    end else begin
      if (xfer_stb) begin m_su = m_pu; m_sd = m_pd; end
      m_pu = su | (m_pu & ~cu);                                 // R11
      m_pd = sd | (m_pd & ~cd);
      m_t3 = wovr_stb && pos && s == 3'd3;
      m_dl = wovr_stb && pos && s == 3'd4;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    gen_clear = 0; ext_up = '0; ext_dn = '0; xfer_stb = 0; rsel_stb = 0;
    wovr_stb = 0; wovc_stb = 0; wr_bus = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20217));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1 reset");

    // R2/R3: pending without transfer does not move selection
    ext_up = 8'h20; ext_dn = 8'h40; step("R2 pend");
    idle(); step("R3 no-xfer");
    xfer_stb = 1; rsel_stb = 1; step("R3 xfer");
    idle(); rsel_stb = 1; step("R6 addr");
    // R5 conflict on cell 3
    ext_up = 8'h08; ext_dn = 8'h08; step("R5 both");
    idle(); xfer_stb = 1; step("R5 nop");
    // R9: cell 3 positive overflow -> t3 pulse; R7 clears cell 3
    idle(); wovr_stb = 1; wr_bus = 16'h4000; step("R9 t3");
    idle(); step("R9 pulse end");
    xfer_stb = 1; step("R7 cleared");
    // R8 chain from cell 2 to cell 1, with R11 set-wins on cell 2
    idle(); gen_clear = 1; step("R1 clear");
    idle(); ext_up = 8'h04; step("R8 req");
    idle(); xfer_stb = 1; step("R8 xfer");
    idle(); wovr_stb = 1; wr_bus = 16'h4000; ext_up = 8'h04; step("R11 set wins");
    idle(); xfer_stb = 1; step("R8 chained");
    // R10/R12: overflow-counter routing and decode
    idle(); wovc_stb = 1; wr_bus = 16'h8000; step("R10 neg");
    idle(); xfer_stb = 1; step("R12 dec");
    idle(); wovc_stb = 1; wr_bus = 16'hC000; step("R12 none");
    idle(); wovr_stb = 1; wr_bus = 16'h8000; step("R9 neg no irq");
    idle(); xfer_stb = 1; step("R10 after");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(3) == 0) ext_up = 8'(1 << $urandom_range(7));
      if ($urandom_range(4) == 0) ext_dn = 8'(1 << $urandom_range(7));
      xfer_stb  = ($urandom_range(2) == 0);
      rsel_stb  = ($urandom_range(1) == 0);
      wovr_stb  = ($urandom_range(2) == 0);
      wovc_stb  = ($urandom_range(5) == 0);
      wr_bus    = 16'($urandom);
      gen_clear = ($urandom_range(150) == 0);
      step("rand");
    end
    idle();
    step("R1 end");
    finish_run();
  end
endmodule